// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block lets a host on a two-wire SMBus/I2C-style bus read and write an 8-bit-addressed configuration register file. It oversamples the clock and data lines with the system clock, recognises start and stop conditions, and compares the incoming device address with a 7-bit identity. The upper three bits of that identity are fixed. The lower four bits come from strap inputs. A matched write carries a register pointer and then one data byte. The data byte is handed to the register file as a one-cycle write strobe, and only once the stop condition arrives. A matched read sets the pointer in the same way, then uses a repeated start and shifts one register byte back to the host.

The data line is open-drain. The block only pulls it low by raising `sda_oe`. The register file stays outside the block. It supplies the read value and a read-only flag for the addressed register. Writing code 0x01 to register 0x00 does not produce a normal write. Instead it produces a restore pulse that returns the register file to its defaults. A separate monitor watches how long both lines stay high and reports when the bus is idle. If that timeout fires in the middle of a transfer, the transfer is abandoned.

Top module: `cfgbus_slave`

## Requirements
- R1: The device address byte holds 101 in bits 7..5, `addr_strap[3:0]` in bits 4..1 and R/W in bit 0 (0 = write, 1 = read). With straps 0000 the write byte is 0xA0, and with 0001 it is 0xA2.
- R2: An SDA fall while SCL is high is a START. An SDA rise while SCL is high is a STOP. Other data bits are sampled on SCL rising edges, most significant bit first.
- R3: For a matched address byte, a pointer byte and the first data byte, the slave pulls SDA low (`sda_oe`=1) for the ninth clock and releases it after that clock's falling edge. An address byte that does not match gets no acknowledge.
- R4: A write commits only when STOP follows an acknowledged data byte. The commit is a single-cycle `reg_wr_en` pulse with `reg_addr` equal to the pointer and `reg_wr_data` equal to the data byte.
- R5: A read is a pointer write, then a repeated START, then the address byte with R/W=1. The slave acknowledges it and sends `reg_rd_data` for `reg_addr`, most significant bit first, driving `sda_oe` as the inverse of each bit. It releases SDA for the host's acknowledge bit.
- R6: An address byte with R/W=1 that is not preceded by a pointer byte in the same transaction is not acknowledged.
- R7: A STOP before the data byte, or a repeated START after it, discards the transaction without any write.
- R8: Bytes after the first data byte are not acknowledged. The first data byte still commits at STOP.
- R9: If `reg_ro` is high for the pointed register when the write commits, the bytes are still acknowledged but no `reg_wr_en` pulse is produced.
- R10: Data 0x01 written to register 0x00 produces a single-cycle `cfg_restore` pulse instead of `reg_wr_en`. Any other value written to register 0x00 is an ordinary write.
- R11: While `en_strap` is low the slave never drives SDA and never produces a write or a restore.
- R12: `bus_idle` goes high once both lines have been high for more than TBUF_CYC cycles since the last STOP or reset, or for more than THIGH_CYC cycles in any case. It falls when either line goes low. A timeout that occurs during a transfer returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| en_strap | input | 1 | Enables the interface when high |
| addr_strap | input | 4 | Low four bits of the 7-bit device address |
| scl_i | input | 1 | Raw bus clock line level |
| sda_i | input | 1 | Raw bus data line level |
| sda_oe | output | 1 | Pulls the data line low when high |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_wr_data | output | 8 | Data for the committed write |
| reg_rd_data | input | 8 | Contents of the register at `reg_addr` |
| reg_ro | input | 1 | Register at `reg_addr` is read-only |
| cfg_restore | output | 1 | Single-cycle pulse that restores register defaults |
| bus_idle | output | 1 | Bus-idle indication from the timeout monitor |

## Verification
The assertions take for granted that the host changes SDA only while SCL is low, except at start and stop conditions. They also assume each SCL level is held longer than the three-cycle path through the synchronizer and edge detector, and that the host releases SDA whenever the slave owns the acknowledge slot or a read bit. The stimulus meets these conditions by building every bus phase from quarter-bit steps of six system clocks and by modelling the wired-AND line as the host level ANDed with the inverse of `sda_oe`. Only the timeout test holds both lines high past THIGH_CYC on purpose, and it does so without any SDA edge while SCL is high.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    localparam int BYTE_W       = 8;
    localparam int STRAP_W      = 4;
    localparam int BITCNT_W     = $clog2(BYTE_W + 1);
    localparam logic [2:0] ID_HIGH = 3'b101;
    localparam logic [BYTE_W-1:0] RESTORE_REG  = 8'h00;
    localparam logic [BYTE_W-1:0] RESTORE_CODE = 8'h01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_WAIT
    } phase_e;

    typedef enum logic [1:0] {
        BY_DEV,
        BY_PTR,
        BY_DATA,
        BY_EXTRA
    } byte_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [6:0] dev_id(input logic [STRAP_W-1:0] strap);
        return {ID_HIGH, strap};
    endfunction

    function automatic logic is_restore(input wr_req_t r);
        return (r.ptr == RESTORE_REG) && (r.data == RESTORE_CODE);
    endfunction

endpackage

// File: rtl/cfgbus_line_sync.sv
module cfgbus_line_sync
    import cfgbus_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_lvl,
    output logic    sda_lvl
);

    logic [DEPTH-1:0] scl_pipe;
    logic [DEPTH-1:0] sda_pipe;
    logic             scl_q;
    logic             sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
            scl_q    <= scl_pipe[DEPTH-1];
            sda_q    <= sda_pipe[DEPTH-1];
        end
    end

    assign scl_lvl = scl_pipe[DEPTH-1];
    assign sda_lvl = sda_pipe[DEPTH-1];

    always_comb begin
        ev.start = scl_lvl & scl_q & sda_q & ~sda_lvl;
        ev.stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;
        ev.rise  = scl_lvl & ~scl_q;
        ev.fall  = ~scl_lvl & scl_q;
        ev.sda   = sda_lvl;
    end

endmodule

// File: rtl/cfgbus_idle_mon.sv
module cfgbus_idle_mon #(
    parameter int TBUF_CYC  = 16,
    parameter int THIGH_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_lvl,
    input  logic sda_lvl,
    input  logic start_det,
    input  logic stop_det,
    output logic bus_idle
);

    localparam int CW = $clog2(THIGH_CYC + 1);
    localparam logic [CW-1:0] TBUF_LIM  = CW'(TBUF_CYC);
    localparam logic [CW-1:0] THIGH_LIM = CW'(THIGH_CYC);

    logic [CW-1:0] high_cnt;
    logic          after_stop;
    logic          both_high;

    assign both_high = scl_lvl & sda_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt   <= '0;
            after_stop <= 1'b1;
            bus_idle   <= 1'b0;
        end else begin
            if (stop_det) begin
                after_stop <= 1'b1;
            end else if (start_det) begin
                after_stop <= 1'b0;
            end
            if (!both_high) begin
                high_cnt <= '0;
            end else if (high_cnt != THIGH_LIM) begin
                high_cnt <= high_cnt + 1'b1;
            end
            bus_idle <= both_high &&
                        ((after_stop && high_cnt >= TBUF_LIM) || high_cnt >= THIGH_LIM);
        end
    end

endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
    import cfgbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  bus_ev_t            ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic               bus_idle,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  ptr,
    output wr_req_t            req,
    output logic               commit_req
);

    phase_e              phase;
    byte_e               which;
    logic [BITCNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic                ptr_ok;
    logic                pending;
    logic                rd_go;
    logic [BYTE_W-1:0]   data_q;
    logic                id_match;

    assign id_match = (rx_sh[BYTE_W-1:1] == dev_id(strap));
    assign req.ptr  = ptr;
    assign req.data = data_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase      <= PH_IDLE;
            which      <= BY_DEV;
            bitcnt     <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            ptr_ok     <= 1'b0;
            pending    <= 1'b0;
            rd_go      <= 1'b0;
            sda_oe     <= 1'b0;
            commit_req <= 1'b0;
            if (rst) begin
                ptr    <= '0;
                data_q <= '0;
            end
        end else begin
            commit_req <= 1'b0;
            if (bus_idle && phase != PH_IDLE) begin
                phase   <= PH_IDLE;
                sda_oe  <= 1'b0;
                pending <= 1'b0;
                ptr_ok  <= 1'b0;
                rd_go   <= 1'b0;
            end else if (ev.stop) begin
                commit_req <= pending;
                pending    <= 1'b0;
                ptr_ok     <= 1'b0;
                rd_go      <= 1'b0;
                phase      <= PH_IDLE;
                sda_oe     <= 1'b0;
            end else if (ev.start) begin
                phase   <= PH_RX;
                which   <= BY_DEV;
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
                pending <= 1'b0;
                rd_go   <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RX: begin
                        if (ev.rise) begin
                            rx_sh  <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == BITCNT_W'(BYTE_W)) begin
                            bitcnt <= '0;
                            unique case (which)
                                BY_DEV: begin
                                    if (id_match && !rx_sh[0]) begin
                                        phase  <= PH_ACK;
                                        sda_oe <= 1'b1;
                                        which  <= BY_PTR;
                                    end else if (id_match && ptr_ok) begin
                                        phase  <= PH_ACK;
                                        sda_oe <= 1'b1;
                                        rd_go  <= 1'b1;
                                    end else begin
                                        phase  <= PH_WAIT;
                                    end
                                end
                                BY_PTR: begin
                                    ptr    <= rx_sh;
                                    ptr_ok <= 1'b1;
                                    phase  <= PH_ACK;
                                    sda_oe <= 1'b1;
                                    which  <= BY_DATA;
                                end
                                BY_DATA: begin
                                    data_q  <= rx_sh;
                                    pending <= 1'b1;
                                    phase   <= PH_ACK;
                                    sda_oe  <= 1'b1;
                                    which   <= BY_EXTRA;
                                end
                                default: begin
                                    phase <= PH_WAIT;
                                end
                            endcase
                        end
                    end
                    PH_ACK: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (rd_go) begin
                                rd_go  <= 1'b0;
                                phase  <= PH_TX;
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                phase  <= PH_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bitcnt == BITCNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_WAIT;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cfgbus_commit.sv
module cfgbus_commit
    import cfgbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              commit_req,
    input  wr_req_t           req,
    input  logic              ro,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              restore
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
            restore <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            restore <= 1'b0;
            if (en && commit_req) begin
                wr_data <= req.data;
                if (is_restore(req)) begin
                    restore <= 1'b1;
                end else if (!ro) begin
                    wr_en <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
    import cfgbus_pkg::*;
#(
    parameter int SYNC_DEPTH = 2,
    parameter int TBUF_CYC   = 16,
    parameter int THIGH_CYC  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_strap,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  reg_addr,
    output logic               reg_wr_en,
    output logic [BYTE_W-1:0]  reg_wr_data,
    input  logic [BYTE_W-1:0]  reg_rd_data,
    input  logic               reg_ro,
    output logic               cfg_restore,
    output logic               bus_idle
);

    bus_ev_t ev;
    logic    scl_s;
    logic    sda_s;
    logic    stop_seen;
    wr_req_t req;
    logic    commit_req;

    cfgbus_line_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .ev      (ev),
        .scl_lvl (scl_s),
        .sda_lvl (sda_s)
    );

    assign stop_seen = ev.stop;

    cfgbus_idle_mon #(.TBUF_CYC(TBUF_CYC), .THIGH_CYC(THIGH_CYC)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .scl_lvl   (scl_s),
        .sda_lvl   (sda_s),
        .start_det (ev.start),
        .stop_det  (ev.stop),
        .bus_idle  (bus_idle)
    );

    cfgbus_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .en         (en_strap),
        .ev         (ev),
        .strap      (addr_strap),
        .bus_idle   (bus_idle),
        .rd_data    (reg_rd_data),
        .sda_oe     (sda_oe),
        .ptr        (reg_addr),
        .req        (req),
        .commit_req (commit_req)
    );

    cfgbus_commit u_commit (
        .clk        (clk),
        .rst        (rst),
        .en         (en_strap),
        .commit_req (commit_req),
        .req        (req),
        .ro         (reg_ro),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .restore    (cfg_restore)
    );

endmodule

// File: rtl/cfgbus_checker.sv
module cfgbus_checker (
    input logic       clk,
    input logic       rst,
    input logic       en_strap,
    input logic       sda_oe,
    input logic       reg_wr_en,
    input logic       cfg_restore,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wr_data,
    input logic       bus_idle,
    input logic       scl_s,
    input logic       sda_s,
    input logic       stop_seen
);

    assert_quiet_when_disabled_R11: assert property (@(posedge clk) disable iff (rst)
        !en_strap |=> (!sda_oe && !reg_wr_en && !cfg_restore));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    assert_write_after_stop_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> $past(stop_seen, 2));

    assert_restore_code_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_restore |-> (reg_addr == 8'h00 && reg_wr_data == 8'h01 && !reg_wr_en));

    assert_idle_lines_high_R12: assert property (@(posedge clk) disable iff (rst)
        bus_idle |-> $past(scl_s && sda_s));

    assert_release_on_stop_R7: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_oe);

endmodule

bind cfgbus_slave cfgbus_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_strap    (en_strap),
    .sda_oe      (sda_oe),
    .reg_wr_en   (reg_wr_en),
    .cfg_restore (cfg_restore),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .bus_idle    (bus_idle),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .stop_seen   (stop_seen)
);

// File: tb/sim_cfgbus_slave.sv
module sim_cfgbus_slave;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       en = 1'b1;
    logic [3:0] strap = 4'h0;
    logic       sda_oe, reg_wr_en, cfg_restore, bus_idle, reg_ro;
    logic [7:0] reg_addr, reg_wr_data, reg_rd_data;
    logic       sda_line;

    always #4 clk = ~clk;

    assign sda_line    = sda_h & ~sda_oe;
    assign reg_rd_data = reg_addr ^ 8'h3C;
    assign reg_ro      = reg_addr[7];

    cfgbus_slave u0 (
        .clk         (clk),
        .rst         (rst),
        .en_strap    (en),
        .addr_strap  (strap),
        .scl_i       (scl_h),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .reg_ro      (reg_ro),
        .cfg_restore (cfg_restore),
        .bus_idle    (bus_idle)
    );

    typedef struct {
        bit         restore;
        logic [7:0] a;
        logic [7:0] d;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    bit   watch = 1'b0;
    bit   oe_seen = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin : mon
        exp_t e;
        if (!rst && (reg_wr_en || cfg_restore)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4 R7 R9 unexpected commit", {15'd0, cfg_restore, reg_addr, reg_wr_data}, 32'd0);
            end else begin
                e = sb.pop_front();
                chk(e.restore == cfg_restore && e.a == reg_addr && (e.restore || e.d == reg_wr_data),
                    e.restore ? "R10 restore pulse" : "R2 R4 write commit",
                    {15'd0, cfg_restore, reg_addr, reg_wr_data}, {15'd0, e.restore, e.a, e.d});
            end
        end
        if (watch && sda_oe) oe_seen = 1'b1;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; scl_h = 1'b1; wq();
        sda_h = 1'b0; wq();
        scl_h = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_h = 1'b1; wq();
        scl_h = 1'b1; wq();
        sda_h = 1'b0; wq();
        scl_h = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wq();
        scl_h = 1'b1; wq();
        sda_h = 1'b1; wq(); wq(); wq();
    endtask

    task automatic clk_bit(input bit b, output bit seen);
        sda_h = b; wq();
        scl_h = 1'b1; wq();
        seen = sda_line;
        wq();
        scl_h = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(output logic [7:0] d, output bit released);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(1'b1, s);
        released = s;
    endtask

    task automatic do_write(input logic [7:0] dev, input logic [7:0] p, input logic [7:0] d, input string tag);
        bit a0, a1, a2;
        bus_start();
        send_byte(dev, a0);
        send_byte(p, a1);
        send_byte(d, a2);
        bus_stop();
        chk(a0 && a1 && a2, tag, {29'd0, a0, a1, a2}, 32'h7);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : drv
        bit a0, a1, a2, a3, rel;
        logic [7:0] rd;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sda_oe && !reg_wr_en && !cfg_restore, "R11 reset outputs idle",
            {29'd0, sda_oe, reg_wr_en, cfg_restore}, 32'd0);
        repeat (30) @(negedge clk);

        // R1 R3 R4: straps 0000, address byte 0xA0
        sb.push_back('{1'b0, 8'h12, 8'h5A});
        do_write(8'hA0, 8'h12, 8'h5A, "R1 R3 acks for 0xA0 write");
        repeat (20) @(negedge clk);
        chk(bus_idle, "R12 idle after stop", {31'd0, bus_idle}, 32'd1);

        // R5 read with repeated start
        bus_start();
        chk(!bus_idle, "R12 idle low in transfer", {31'd0, bus_idle}, 32'd0);
        send_byte(8'hA0, a0);
        send_byte(8'h12, a1);
        bus_rstart();
        send_byte(8'hA1, a2);
        recv_byte(rd, rel);
        bus_stop();
        chk(a0 && a1 && a2, "R5 read acks", {29'd0, a0, a1, a2}, 32'h7);
        chk(rd == (8'h12 ^ 8'h3C), "R5 read data", {24'd0, rd}, {24'd0, 8'h12 ^ 8'h3C});
        chk(rel, "R5 SDA released for host NACK", {31'd0, rel}, 32'd1);

        // R1 R3 mismatch
        bus_start();
        send_byte(8'hA4, a0);
        send_byte(8'h12, a1);
        bus_stop();
        chk(!a0 && !a1, "R1 R3 mismatched address not acked", {30'd0, a0, a1}, 32'd0);

        // R1 strap 0001
        strap = 4'h1;
        sb.push_back('{1'b0, 8'h20, 8'h11});
        do_write(8'hA2, 8'h20, 8'h11, "R1 strap 0001 gives 0xA2");

        // R7 stop after pointer
        bus_start();
        send_byte(8'hA2, a0);
        send_byte(8'h30, a1);
        bus_stop();
        chk(a0 && a1, "R7 acks before abort", {30'd0, a0, a1}, 32'h3);

        // R7 repeated start after data byte
        bus_start();
        send_byte(8'hA2, a0);
        send_byte(8'h31, a1);
        send_byte(8'h44, a2);
        bus_rstart();
        bus_stop();
        chk(a2, "R7 data acked then discarded", {31'd0, a2}, 32'd1);

        // R9 read-only register
        do_write(8'hA2, 8'h85, 8'h77, "R9 read-only write acked");

        // R10 restore code and plain write of register 0
        sb.push_back('{1'b1, 8'h00, 8'h01});
        do_write(8'hA2, 8'h00, 8'h01, "R10 restore command acked");
        sb.push_back('{1'b0, 8'h00, 8'h02});
        do_write(8'hA2, 8'h00, 8'h02, "R10 other value is a write");

        // R6 read without pointer
        bus_start();
        send_byte(8'hA3, a0);
        bus_stop();
        chk(!a0, "R6 read without pointer not acked", {31'd0, a0}, 32'd0);

        // R8 extra byte
        sb.push_back('{1'b0, 8'h40, 8'h66});
        bus_start();
        send_byte(8'hA2, a0);
        send_byte(8'h40, a1);
        send_byte(8'h66, a2);
        send_byte(8'h77, a3);
        bus_stop();
        chk(a0 && a1 && a2 && !a3, "R8 extra byte not acked", {28'd0, a0, a1, a2, a3}, 32'hE);

        // R11 disabled
        en = 1'b0;
        repeat (3) @(negedge clk);
        watch = 1'b1;
        bus_start();
        send_byte(8'hA2, a0);
        send_byte(8'h50, a1);
        send_byte(8'h99, a2);
        bus_stop();
        watch = 1'b0;
        chk(!oe_seen && !a0, "R11 no drive while disabled", {30'd0, oe_seen, a0}, 32'd0);
        en = 1'b1;
        repeat (10) @(negedge clk);

        // R12 THIGH timeout without stop
        bus_start();
        send_byte(8'hA2, a0);
        sda_h = 1'b1; wq();
        scl_h = 1'b1;
        repeat (30) @(negedge clk);
        chk(!bus_idle, "R12 no idle before THIGH without stop", {31'd0, bus_idle}, 32'd0);
        repeat (50) @(negedge clk);
        chk(bus_idle, "R12 idle after THIGH", {31'd0, bus_idle}, 32'd1);
        sb.push_back('{1'b0, 8'h60, 8'hC3});
        do_write(8'hA2, 8'h60, 8'hC3, "R12 recovers after timeout");

        repeat (20) @(negedge clk);
        chk(sb.size() == 0, "R4 all expected commits seen", sb.size(), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule